// File: doc/BRIEF.md
# Time-Tagged Serial Receive Channel

This block receives 8N1 asynchronous serial characters and tags each one with the time it began to arrive. A shared free-running count is sampled when the falling edge of a start bit is first seen. When the character completes with a valid stop bit, the 24-bit count and the 8-bit character are joined into one 32-bit word. That word is written into a 128-entry queue that a host drains in blocks.

The host sets the bit rate by writing a divisor. The line is oversampled at sixteen ticks per bit. A start bit is accepted only if the line is still low at the middle of the bit. The host is not alerted once per character. Instead an almost-full flag asks for service when the queue passes a threshold. A character that arrives while the queue is full is dropped, and a sticky overrun flag is set.

Top module: `stamp_rx_channel`

## Requirements
- R1: Reset state. While `rst_n` is low and after it rises, `rd_valid`, `almost_full` and `overrun` are 0.
- R2: Word format. Each stored word carries the received character in bits 7:0 and the captured count in bits 31:8. Data bits arrive least significant first, framed as one low start bit, eight data bits and one high stop bit.
- R3: Capture instant. The stored count equals the value `count_in` holds at the third rising clock edge after `rx_line` first goes low. That is two synchroniser stages plus the detecting edge, and it is not taken at the end of the character.
- R4: Bit rate. The divisor `D` written through `div_we`/`div_wdata` gives a bit period of 16*(D+1) clocks. After reset the divisor is `DIV_RESET` (default 26).
- R5: False start. A low pulse that returns high before the middle of the start bit stores nothing.
- R6: Framing error. A character whose stop bit samples low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: Queue order and depth. Words come out in arrival order. The queue holds up to 128 words. `rd_data` shows the oldest word whenever `rd_valid` is 1, and `rd_en` removes it.
- R8: Threshold. `almost_full` is 1 exactly when the queue holds at least `AF_LEVEL` words (default 96).
- R9: Overrun. A character that completes while the queue is full is dropped, and the stored words are kept. The drop sets `overrun`, which stays set until `overrun_clr` is pulsed. A drop in the same cycle as the clear wins.
- R10: Empty read. `rd_en` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_we | input | 1 | Write strobe for the bit-rate divisor |
| div_wdata | input | 16 | New divisor value D |
| count_in | input | 24 | Shared free-running count to be sampled |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Removes the oldest word |
| overrun_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 32 | Oldest word: {count, character} |
| rd_valid | output | 1 | Queue holds at least one word |
| almost_full | output | 1 | Level at or above threshold |
| overrun | output | 1 | Sticky: a character was dropped on a full queue |

## Verification
Characters with all-zero, all-one, alternating and single-set-bit payloads are sent at three divisors and at the reset divisor. A wrong bit order, a wrong sampling point or a wrong bit rate each corrupt a different subset of these payloads. The count stamp is compared against the count two clocks after the line falls, which separates capture at the start edge from capture at the stop bit. A short low glitch and a low stop bit, each followed by a good character, show that a rejected frame leaves no word and does not shift the next stamp. A run of 129 characters checks the threshold edge at 95 and 96 words, overrun on the 129th character, and the arrival order of the retained 128 while they are drained.

// File: rtl/stamp_rx_pkg.sv
package stamp_rx_pkg;
  localparam int STAMP_W = 24;
  localparam int CHAR_W  = 8;
  localparam int WORD_W  = STAMP_W + CHAR_W;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // Join a count stamp and a character into one queue word.
  function automatic logic [WORD_W-1:0] pack_word(
      input logic [STAMP_W-1:0] stamp,
      input logic [CHAR_W-1:0]  ch);
    return {stamp, ch};
  endfunction

  // Queue level at or above the service threshold.
  function automatic logic over_mark(input int unsigned lvl, input int unsigned mark);
    return lvl >= mark;
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             wrap;

  assign wrap = (phase_q >= div);
  assign tick = wrap && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (wrap)    phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import stamp_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line,
  input  logic               tick,
  input  logic [STAMP_W-1:0] count_in,
  output logic               start_evt,
  output logic               push_evt,
  output logic               frame_err_evt,
  output logic [WORD_W-1:0]  word
);
  localparam int SC_W     = $clog2(OVERSAMPLE);
  localparam int BIT_W    = $clog2(CHAR_W);
  localparam int MID_TICK = OVERSAMPLE / 2 - 1;
  localparam int END_TICK = OVERSAMPLE - 1;

  rx_state_e          state_q;
  logic [SC_W-1:0]    scnt_q;
  logic [BIT_W-1:0]   bitn_q;
  logic [CHAR_W-1:0]  shreg_q;
  logic [STAMP_W-1:0] stamp_q;
  logic               at_mid;
  logic               at_end;

  assign at_mid = tick && (scnt_q == SC_W'(MID_TICK));
  assign at_end = tick && (scnt_q == SC_W'(END_TICK));

  assign start_evt     = (state_q == RX_IDLE) && !line;
  assign push_evt      = (state_q == RX_STOP) && at_end && line;
  assign frame_err_evt = (state_q == RX_STOP) && at_end && !line;
  assign word          = pack_word(stamp_q, shreg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      scnt_q  <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      stamp_q <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (start_evt) begin
            state_q <= RX_START;
            stamp_q <= count_in;
            scnt_q  <= '0;
          end
        end
        RX_START: begin
          if (at_mid) begin
            scnt_q <= '0;
            bitn_q <= '0;
            if (!line) state_q <= RX_DATA;
            else       state_q <= RX_IDLE;
          end else if (tick) begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_end) begin
            shreg_q <= {line, shreg_q[CHAR_W-1:1]};
            scnt_q  <= '0;
            if (bitn_q == BIT_W'(CHAR_W - 1)) state_q <= RX_STOP;
            else                              bitn_q  <= bitn_q + 1'b1;
          end else if (tick) begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_end) begin
            scnt_q  <= '0;
            state_q <= line ? RX_IDLE : RX_HOLD;
          end else if (tick) begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (line) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo
  import stamp_rx_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int AF_LEVEL = 96
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [WORD_W-1:0]           wdata,
  input  logic                        pop,
  output logic [WORD_W-1:0]           rdata,
  output logic                        not_empty,
  output logic                        full,
  output logic                        almost_full,
  output logic                        drop,
  output logic [$clog2(DEPTH):0]      level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              do_push, do_pop;

  assign full        = (lvl_q == LVL_W'(DEPTH));
  assign not_empty   = (lvl_q != '0);
  assign do_push     = push && !full;
  assign do_pop      = pop && not_empty;
  assign drop        = push && full;
  assign rdata       = mem[rptr_q];
  assign level       = lvl_q;
  assign almost_full = over_mark(int'(lvl_q), AF_LEVEL);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/stamp_rx_channel.sv
module stamp_rx_channel
  import stamp_rx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DIV_RESET   = 26,
  parameter int DEPTH       = 128,
  parameter int AF_LEVEL    = 96,
  parameter int SYNC_STAGES = 2,
  parameter int OVERSAMPLE  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_we,
  input  logic [DIV_W-1:0]   div_wdata,
  input  logic [STAMP_W-1:0] count_in,
  input  logic               rx_line,
  input  logic               rd_en,
  input  logic               overrun_clr,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               almost_full,
  output logic               overrun
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic [DIV_W-1:0]  div_q;
  logic              line_s;
  logic              tick;
  logic              start_evt;
  logic              push_evt;
  logic              frame_err_evt;
  logic              drop_evt;
  logic              fifo_full;
  logic [WORD_W-1:0] rx_word;
  logic [LVL_W-1:0]  fifo_level;
  logic              overrun_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= DIV_W'(DIV_RESET);
    else if (div_we) div_q <= div_wdata;
  end

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_line),
    .d_out (line_s)
  );

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_evt),
    .div     (div_q),
    .tick    (tick)
  );

  rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .line          (line_s),
    .tick          (tick),
    .count_in      (count_in),
    .start_evt     (start_evt),
    .push_evt      (push_evt),
    .frame_err_evt (frame_err_evt),
    .word          (rx_word)
  );

  stamp_fifo #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push_evt),
    .wdata       (rx_word),
    .pop         (rd_en),
    .rdata       (rd_data),
    .not_empty   (rd_valid),
    .full        (fifo_full),
    .almost_full (almost_full),
    .drop        (drop_evt),
    .level       (fifo_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           overrun_q <= 1'b0;
    else if (drop_evt)    overrun_q <= 1'b1;
    else if (overrun_clr) overrun_q <= 1'b0;
  end

  assign overrun = overrun_q;
endmodule

// File: rtl/stamp_rx_checker.sv
module stamp_rx_checker #(
  parameter int DEPTH    = 128,
  parameter int AF_LEVEL = 96
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic                     rd_valid,
  input logic                     almost_full,
  input logic                     overrun,
  input logic                     overrun_clr,
  input logic                     start_evt,
  input logic                     push_evt,
  input logic                     frame_err_evt,
  input logic                     drop_evt,
  input logic                     fifo_full,
  input logic [$clog2(DEPTH):0]   fifo_level
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun);

  // R9
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_en) |=> fifo_full);

  // R10
  pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> $past(rd_en));

  // R8
  af_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(almost_full) |-> $past(push_evt));

  // R3
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !start_evt);

  // R6
  frame_err_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_evt |-> !push_evt);
endmodule

bind stamp_rx_channel stamp_rx_checker #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_en         (rd_en),
  .rd_valid      (rd_valid),
  .almost_full   (almost_full),
  .overrun       (overrun),
  .overrun_clr   (overrun_clr),
  .start_evt     (start_evt),
  .push_evt      (push_evt),
  .frame_err_evt (frame_err_evt),
  .drop_evt      (drop_evt),
  .fifo_full     (fifo_full),
  .fifo_level    (fifo_level)
);

// File: tb/sim_stamp_rx_channel.sv
`timescale 1ns/1ps
module sim_stamp_rx_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_we = 1'b0;
  logic [15:0] div_wdata = '0;
  logic [23:0] cnt = 24'h00F000;
  logic        rx = 1'b1;
  logic        rd_en = 1'b0;
  logic        ovr_clr = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        almost_full;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  logic [23:0] stamps [128];

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 24'd1;

  stamp_rx_channel u0 (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
    .count_in(cnt), .rx_line(rx), .rd_en(rd_en), .overrun_clr(ovr_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .almost_full(almost_full),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div_we = 1'b1;
    div_wdata = 16'(d);
    @(negedge clk);
    div_we = 1'b0;
  endtask

  // Sends one frame; returns the count expected in the stamp (R3).
  task automatic send_char(input logic [7:0] ch, input logic stop_lvl, input int d,
                           output logic [23:0] exp_stamp);
    int bitlen;
    bitlen = 16 * (d + 1);
    @(negedge clk);
    rx = 1'b0;
    exp_stamp = cnt + 24'd2;
    clocks(bitlen);
    for (int i = 0; i < 8; i++) begin
      rx = ch[i];
      clocks(bitlen);
    end
    rx = stop_lvl;
    clocks(bitlen);
    rx = 1'b1;
    clocks(bitlen);
  endtask

  task automatic pop_check(input logic [31:0] exp, input string req);
    @(negedge clk);
    check(rd_valid === 1'b1, req, {31'd0, rd_valid}, 32'd1);
    check(rd_data === exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] st;
    logic [7:0]  pat [8];
    int          divs [3];
    pat  = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h3C, 8'hC5};
    divs = '{0, 1, 3};

    clocks(4);
    // R1 during reset
    check({rd_valid, almost_full, overrun} === 3'b000, "R1", {29'd0, rd_valid, almost_full, overrun}, 32'd0);
    rst_n = 1'b1;
    clocks(2);
    // R1 after reset
    check({rd_valid, almost_full, overrun} === 3'b000, "R1", {29'd0, rd_valid, almost_full, overrun}, 32'd0);

    // R10: read on empty queue has no effect
    rd_en = 1'b1;
    clocks(3);
    rd_en = 1'b0;
    clocks(1);
    check(rd_valid === 1'b0, "R10", {31'd0, rd_valid}, 32'd0);

    // R4: reset divisor 26
    send_char(8'h96, 1'b1, 26, st);
    pop_check({st, 8'h96}, "R4");
    check(rd_valid === 1'b0, "R10", {31'd0, rd_valid}, 32'd0);

    // R2 R3 R4: payload sweep at several divisors
    foreach (divs[k]) begin
      set_div(divs[k]);
      foreach (pat[j]) begin
        send_char(pat[j], 1'b1, divs[k], st);
        pop_check({st, pat[j]}, "R2/R3");
      end
    end

    // R5: glitch shorter than half a bit
    set_div(1);
    @(negedge clk);
    rx = 1'b0;
    clocks(8);
    rx = 1'b1;
    clocks(96);
    check(rd_valid === 1'b0, "R5", {31'd0, rd_valid}, 32'd0);
    send_char(8'h5A, 1'b1, 1, st);
    pop_check({st, 8'h5A}, "R5");
    check(rd_valid === 1'b0, "R5", {31'd0, rd_valid}, 32'd0);

    // R6: low stop bit discards the character, next one is clean
    send_char(8'hE7, 1'b0, 1, st);
    clocks(4);
    check(rd_valid === 1'b0, "R6", {31'd0, rd_valid}, 32'd0);
    send_char(8'h18, 1'b1, 1, st);
    pop_check({st, 8'h18}, "R6");

    // R7 R8 R9: fill to the limit at the fastest rate
    set_div(0);
    for (int i = 0; i < 129; i++) begin
      logic [23:0] s;
      send_char(8'((i * 7 + 3) & 255), 1'b1, 0, s);
      if (i < 128) stamps[i] = s;
      if (i == 94) check(almost_full === 1'b0, "R8", {31'd0, almost_full}, 32'd0);
      if (i == 95) check(almost_full === 1'b1, "R8", {31'd0, almost_full}, 32'd1);
      if (i == 127) check(overrun === 1'b0, "R9", {31'd0, overrun}, 32'd0);
    end
    check(overrun === 1'b1, "R9", {31'd0, overrun}, 32'd1);

    for (int i = 0; i < 128; i++) begin
      pop_check({stamps[i], 8'((i * 7 + 3) & 255)}, "R7");
      check(almost_full === ((127 - i) >= 96), "R8", {31'd0, almost_full},
            {31'd0, ((127 - i) >= 96)});
    end
    check(rd_valid === 1'b0, "R7", {31'd0, rd_valid}, 32'd0);
    check(overrun === 1'b1, "R9", {31'd0, overrun}, 32'd1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check(overrun === 1'b0, "R9", {31'd0, overrun}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule